// File: doc/BRIEF.md
# Packet Timestamp Capture Bank

The block stores packet timestamps for a group of network ports. Each port has a fixed number of slots. Every slot can hold one 40-bit sample of that port's timer. When a packet event arrives on a port, it names a slot index. A receive event always samples the timer into that slot. A transmit event samples it only when the packet carries a timestamp request.

Software reads each slot through an addressed 32-bit register interface. One address bank returns the lower 32 bits of the sample. A second bank returns the upper 8 bits together with a valid flag. Software frees a slot by writing zero to its registers. If an event targets a slot that still holds an unread sample, the new sample is dropped and the port's sticky overflow flag is raised.

Top module: `ts_capture_bank`

## Requirements
- R1: After reset every slot is invalid, every register reads zero and every overflow flag is low.
- R2: An accepted event on port p with index i loads that port's 40-bit timer value into slot p*SLOTS+i and sets its valid flag. The result is readable from the clock cycle after the capturing edge.
- R3: A receive event (evt_tx_i=0) is always eligible for capture. A transmit event (evt_tx_i=1) is eligible only when evt_req_i=1. An ineligible transmit event leaves the slot and the overflow flag unchanged.
- R4: The low bank occupies word addresses LOW_BASE (default 0x000) + p*SLOTS + i. A read there returns timestamp bits [31:0].
- R5: The high bank occupies word addresses HIGH_BASE (default 0x100) + p*SLOTS + i. A read there returns timestamp bits [39:32] in bits [7:0] and the valid flag in bit 8. Bits [31:9] read zero.
- R6: An eligible event aimed at a slot that is already valid is dropped and leaves the slot contents unchanged. It sets the port's overflow flag, which stays set until reset.
- R7: Writing zero to a low-bank register clears bits [31:0] of that slot. Writing zero to a high-bank register clears bits [39:32] and the valid flag. Writing any non-zero value has no effect.
- R8: The capture decision uses the valid flag held before the clock edge. If a capture is accepted in the same cycle as a clearing write to the same slot, the capture wins. If the slot was valid, the event is dropped and the clearing write still takes effect.
- R9: Ports capture independently in the same cycle. A read from an address outside both banks returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_time_i | input | NUM_PORTS*40 | Timer value of each port, port p at bits [p*40 +: 40] |
| evt_vld_i | input | NUM_PORTS | Packet event strobe per port |
| evt_tx_i | input | NUM_PORTS | 1 = transmit event, 0 = receive event |
| evt_req_i | input | NUM_PORTS | Timestamp request that accompanies a transmit event |
| evt_idx_i | input | NUM_PORTS*IDX_W | Slot index per port |
| reg_addr_i | input | ADDR_W | Word address for reads and writes |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| ovf_o | output | NUM_PORTS | Sticky overflow flag per port |

## Verification
The bench drives four kinds of input pattern:
- **Receive events alone** show that the timer value lands in the slot named by port and index.
- **Transmit events with and without a request** separate captured packets from ignored ones.
- **Repeated events on an occupied slot** tell a dropped capture apart from an overwrite, and show that the overflow flag stays set.
- **Zero and non-zero writes, some in the same cycle as captures**, show that clearing acts per register and that a capture wins over a clear.

A long phase then applies random events and writes. A behavioural model is compared with every read and every overflow flag on each clock.

// File: rtl/ts_bank_pkg.sv
`timescale 1ns/1ps
package ts_bank_pkg;
  localparam int TS_W  = 40;
  localparam int LO_W  = 32;
  localparam int HI_W  = TS_W - LO_W;
  localparam int REG_W = 32;
endpackage

// File: rtl/ts_slot.sv
`timescale 1ns/1ps
module ts_slot
  import ts_bank_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hit_i,
  input  logic            clr_lo_i,
  input  logic            clr_hi_i,
  input  logic [TS_W-1:0] time_i,
  output logic [TS_W-1:0] ts_o,
  output logic            valid_o,
  output logic            drop_o
);
  logic [TS_W-1:0] ts_q;
  logic            valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q    <= '0;
      valid_q <= 1'b0;
    end else if (hit_i && !valid_q) begin
      ts_q    <= time_i;
      valid_q <= 1'b1;
    end else begin
      if (clr_lo_i) ts_q[LO_W-1:0] <= '0;
      if (clr_hi_i) begin
        ts_q[TS_W-1:LO_W] <= '0;
        valid_q           <= 1'b0;
      end
    end
  end

  assign ts_o    = ts_q;
  assign valid_o = valid_q;
  assign drop_o  = hit_i && valid_q;

  AST_CAPTURE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !valid_o) |=> (valid_o && ts_o == $past(time_i))); // R2
  AST_DROP_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && valid_o && !clr_lo_i && !clr_hi_i) |=> (valid_o && $stable(ts_o))); // R6
  AST_CLEAR_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hi_i && valid_o) |=> !valid_o); // R7
endmodule

// File: rtl/ts_reg_dec.sv
`timescale 1ns/1ps
module ts_reg_dec #(
  parameter int ADDR_W    = 12,
  parameter int TOTAL     = 8,
  parameter int LOW_BASE  = 'h000,
  parameter int HIGH_BASE = 'h100,
  parameter int SLOT_W    = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              lo_hit_o,
  output logic              hi_hit_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [ADDR_W-1:0] lo_off, hi_off;

  // wrap-around makes addresses below a base compare as out of range
  assign lo_off   = addr_i - ADDR_W'(LOW_BASE);
  assign hi_off   = addr_i - ADDR_W'(HIGH_BASE);
  assign lo_hit_o = lo_off < ADDR_W'(TOTAL);
  assign hi_hit_o = !lo_hit_o && (hi_off < ADDR_W'(TOTAL));
  assign slot_o   = lo_hit_o ? lo_off[SLOT_W-1:0] : hi_off[SLOT_W-1:0];
endmodule

// File: rtl/ts_capture_bank.sv
`timescale 1ns/1ps
module ts_capture_bank
  import ts_bank_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int SLOTS     = 4,
  parameter int IDX_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  parameter int ADDR_W    = 12,
  parameter int LOW_BASE  = 'h000,
  parameter int HIGH_BASE = 'h100
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PORTS*TS_W-1:0] port_time_i,
  input  logic [NUM_PORTS-1:0]      evt_vld_i,
  input  logic [NUM_PORTS-1:0]      evt_tx_i,
  input  logic [NUM_PORTS-1:0]      evt_req_i,
  input  logic [NUM_PORTS*IDX_W-1:0] evt_idx_i,
  input  logic [ADDR_W-1:0]         reg_addr_i,
  input  logic                      reg_wr_i,
  input  logic [REG_W-1:0]          reg_wdata_i,
  output logic [REG_W-1:0]          reg_rdata_o,
  output logic [NUM_PORTS-1:0]      ovf_o
);
  localparam int TOTAL  = NUM_PORTS * SLOTS;
  localparam int SLOT_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;

  logic              lo_hit, hi_hit;
  logic [SLOT_W-1:0] sel;
  logic              wr_zero;
  logic [TOTAL-1:0]  hit, drop, vld;
  logic [TS_W-1:0]   slot_ts [TOTAL];
  logic [NUM_PORTS-1:0] port_drop;
  logic [NUM_PORTS-1:0] ovf_q;

  ts_reg_dec #(
    .ADDR_W(ADDR_W), .TOTAL(TOTAL), .LOW_BASE(LOW_BASE),
    .HIGH_BASE(HIGH_BASE), .SLOT_W(SLOT_W)
  ) u_dec (
    .addr_i(reg_addr_i), .lo_hit_o(lo_hit), .hi_hit_o(hi_hit), .slot_o(sel)
  );

  assign wr_zero = reg_wr_i && (reg_wdata_i == '0);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic elig;
    assign elig = evt_vld_i[p] && (!evt_tx_i[p] || evt_req_i[p]);

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      localparam int K = p * SLOTS + i;
      assign hit[K] = elig && (evt_idx_i[p*IDX_W +: IDX_W] == IDX_W'(i));

      ts_slot u_slot (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hit_i   (hit[K]),
        .clr_lo_i(wr_zero && lo_hit && (sel == SLOT_W'(K))),
        .clr_hi_i(wr_zero && hi_hit && (sel == SLOT_W'(K))),
        .time_i  (port_time_i[p*TS_W +: TS_W]),
        .ts_o    (slot_ts[K]),
        .valid_o (vld[K]),
        .drop_o  (drop[K])
      );

      AST_TX_UNREQ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_vld_i[p] && evt_tx_i[p] && !evt_req_i[p] && !vld[K] &&
         evt_idx_i[p*IDX_W +: IDX_W] == IDX_W'(i)) |=> !vld[K]); // R3
    end

    assign port_drop[p] = |drop[p*SLOTS +: SLOTS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           ovf_q[p] <= 1'b0;
      else if (port_drop[p]) ovf_q[p] <= 1'b1;
    end

    AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o[p] |=> ovf_o[p]); // R6
    AST_OVF_ON_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_drop[p] |=> ovf_o[p]); // R6
  end

  assign ovf_o = ovf_q;

  always_comb begin
    reg_rdata_o = '0;
    if (lo_hit)
      reg_rdata_o = slot_ts[sel][LO_W-1:0];
    else if (hi_hit)
      reg_rdata_o = {{(REG_W-HI_W-1){1'b0}}, vld[sel], slot_ts[sel][TS_W-1:LO_W]};
  end

  AST_HI_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_hit |-> (reg_rdata_o[REG_W-1:HI_W+1] == '0)); // R5
endmodule

// File: tb/ts_capture_bank_tb.sv
`timescale 1ns/1ps
module ts_capture_bank_tb_top;
  localparam int NP = 2, NS = 4, IW = 2, AW = 12, TOT = NP * NS;
  localparam int LB = 'h000, HB = 'h100;

  logic          clk = 0, rst_n = 0;
  logic [NP*40-1:0] ptime;
  logic [NP-1:0] evt_vld = 0, evt_tx = 0, evt_req = 0;
  logic [NP*IW-1:0] evt_idx = 0;
  logic [AW-1:0] addr = 0;
  logic          wr = 0;
  logic [31:0]   wdata = 0;
  logic [31:0]   rdata;
  logic [NP-1:0] ovf;

  ts_capture_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .port_time_i(ptime), .evt_vld_i(evt_vld),
    .evt_tx_i(evt_tx), .evt_req_i(evt_req), .evt_idx_i(evt_idx),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .ovf_o(ovf)
  );

  always #4 clk = ~clk;

  logic [39:0] m_ts [TOT];
  bit          m_v [TOT];
  bit          m_ovf [NP];
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h (addr=%h cyc=%0d)", req, act, exp, addr, cyc);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
    if (int'(a) >= LB && int'(a) < LB + TOT) return m_ts[int'(a) - LB][31:0];
    if (int'(a) >= HB && int'(a) < HB + TOT)
      return {23'b0, m_v[int'(a) - HB], m_ts[int'(a) - HB][39:32]};
    return 32'h0;
  endfunction

  task automatic set_times();
    ptime[39:0]  = 40'h12_0000_0000 + 40'(cyc) * 40'd7;
    ptime[79:40] = 40'hC3_8000_0000 + 40'(cyc) * 40'd13;
  endtask

  task automatic tick();
    @(posedge clk);
    for (int k = 0; k < TOT; k++) begin
      int p = k / NS;
      int i = k % NS;
      bit hit = evt_vld[p] && (!evt_tx[p] || evt_req[p]) && (int'(evt_idx[p*IW +: IW]) == i);
      bit cz  = wr && (wdata == 0);
      if (hit && !m_v[k]) begin
        m_ts[k] = ptime[p*40 +: 40];
        m_v[k]  = 1;
      end else begin
        if (hit) m_ovf[p] = 1;
        if (cz && int'(addr) == LB + k) m_ts[k][31:0] = '0;
        if (cz && int'(addr) == HB + k) begin m_ts[k][39:32] = '0; m_v[k] = 0; end
      end
    end
    @(negedge clk);
    cyc++;
    for (int p = 0; p < NP; p++) check(cur_req, 32'(ovf[p]), 32'(m_ovf[p]));
    check(cur_req, rdata, exp_rd(addr));
    evt_vld = 0; evt_tx = 0; evt_req = 0; wr = 0; wdata = 0;
    set_times();
  endtask

  task automatic ev(int p, int idx, bit tx, bit req);
    evt_vld[p] = 1; evt_tx[p] = tx; evt_req[p] = req; evt_idx[p*IW +: IW] = IW'(idx);
  endtask

  task automatic rd(int a);
    addr = AW'(a);
    tick();
  endtask

  task automatic wrz(int a, logic [31:0] d);
    addr = AW'(a); wr = 1; wdata = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < TOT; k++) begin m_ts[k] = '0; m_v[k] = 0; end
    for (int p = 0; p < NP; p++) m_ovf[p] = 0;
    set_times();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R1";
    for (int k = 0; k < TOT; k++) begin rd(LB + k); rd(HB + k); end

    cur_req = "R2";
    ev(0, 2, 0, 0); rd(LB + 2);
    cur_req = "R4"; rd(LB + 2);
    cur_req = "R5"; rd(HB + 2);

    cur_req = "R3";
    ev(1, 1, 1, 0); rd(HB + NS + 1);
    rd(LB + NS + 1);
    ev(1, 1, 1, 1); rd(HB + NS + 1);
    rd(LB + NS + 1);

    cur_req = "R6";
    ev(0, 2, 0, 0); rd(LB + 2);
    rd(HB + 2);
    ev(1, 1, 1, 1); rd(LB + NS + 1);

    cur_req = "R7";
    wrz(LB + 2, 32'h1); tick(); rd(LB + 2);
    wrz(HB + 2, 32'h100); tick(); rd(HB + 2);
    wrz(LB + 2, 32'h0); tick(); rd(HB + 2);
    wrz(HB + 2, 32'h0); tick(); rd(HB + 2);
    cur_req = "R6"; rd(HB + 2);

    cur_req = "R8";
    ev(0, 0, 0, 0); rd(HB + 0);
    ev(0, 0, 0, 0); wrz(HB + 0, 0); tick(); rd(HB + 0);
    ev(0, 0, 0, 0); wrz(HB + 0, 0); tick(); rd(HB + 0);
    rd(LB + 0);

    cur_req = "R9";
    ev(0, 3, 0, 0); ev(1, 3, 1, 1); rd(LB + 3);
    rd(LB + NS + 3); rd(HB + 3); rd(HB + NS + 3);
    rd(LB + TOT); rd(HB + TOT); rd('h080); rd('hFFF);

    cur_req = "R2";
    for (int n = 0; n < 400; n++) begin
      for (int p = 0; p < NP; p++)
        if ($urandom_range(0, 2) == 0)
          ev(p, int'($urandom_range(0, NS - 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      addr = AW'(($urandom_range(0, 1) ? HB : LB) + int'($urandom_range(0, TOT)));
      if ($urandom_range(0, 3) == 0) begin wr = 1; wdata = $urandom_range(0, 1) ? 32'h0 : 32'h5; end
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule